// File: doc/BRIEF.md
# Real-Time Clock Alarm Comparator with Wildcard Bytes

This block decides, once per clock-update second, whether the current calendar time matches a programmed alarm. It receives the current seconds, minutes, hours and day-of-month bytes after the time has already advanced. It also receives four alarm bytes of the same shape and a one-cycle update strobe. When every field matches on a strobe, it sets a sticky alarm flag. The flag stays set until the host reads the status, and an interrupt line follows the flag whenever the alarm enable is high.

Any alarm byte whose two top bits are both one is a wildcard and matches every current value of that field. With no wildcard the alarm fires once a day. Wildcarding date and hour gives one alarm per hour. Adding the minutes gives one per minute. Wildcarding all four fields gives an alarm on every update. Non-wildcard bytes are compared bit for bit in whatever encoding the time keeper uses: binary or BCD, with the 12-hour PM bit included in the hour byte. Time keeping itself lives outside this block.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset, `alarm_flag` and `alarm_irq` are both 0.
- R2: An alarm byte with bits [7:6] equal to 2'b11 (values C0h to FFh) matches any current value of its field.
- R3: An alarm byte with bits [7:6] not equal to 2'b11 matches only a current byte equal in all 8 bits. For example, hour alarm 81h (PM flag set) does not match current 01h, and BFh does not match 3Fh.
- R4: When `upd_tick` is 1 and all four fields match, `alarm_flag` is 1 after that clock edge. With `upd_tick` at 0, no field values can set the flag.
- R5: `alarm_flag` is sticky. It holds at 1 until a cycle with `stat_rd` at 1, and it is 0 after that edge unless R6 applies.
- R6: If a match strobe and `stat_rd` occur in the same cycle, the flag is 1 after the edge, so the new event wins over the clear.
- R7: `alarm_irq` equals `alarm_flag` AND `alarm_en`. `alarm_en` has no effect on whether the flag is set.
- R8: Wildcards in date and hour make the alarm fire once per hour of a running time sequence. Adding a wildcard in minutes makes it fire once per minute. Wildcards in all four fields make it fire on every update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| upd_tick | input | 1 | One-cycle strobe; current fields hold the newly advanced time |
| now_sec | input | 8 | Current seconds byte |
| now_min | input | 8 | Current minutes byte |
| now_hour | input | 8 | Current hours byte (bit 7 = PM in 12-hour mode) |
| now_date | input | 8 | Current day-of-month byte |
| alm_sec | input | 8 | Seconds alarm byte or wildcard |
| alm_min | input | 8 | Minutes alarm byte or wildcard |
| alm_hour | input | 8 | Hours alarm byte or wildcard |
| alm_date | input | 8 | Date alarm byte or wildcard |
| alarm_en | input | 1 | Interrupt enable for the alarm |
| stat_rd | input | 1 | Host status read; clears the flag |
| alarm_flag | output | 1 | Sticky alarm-occurred flag |
| alarm_irq | output | 1 | Alarm interrupt request |

## Verification
Random stimulus mixes exact copies of the current field, wildcard codes across the full C0h–FFh range, and unrelated values. Because of this mix, a comparator that ignores bits or treats only FFh as a wildcard gives a different flag than the model. Directed cases use near-miss bytes: 81h against 01h and BFh against 3Fh. These separate a true two-bit wildcard test from a one-bit test or a masked compare. Running minute and second sequences with hourly, per-minute and per-second wildcard sets count the alarms, which shows that each field takes part in the match. Same-cycle strobe and read, and strobes with the enable low, separate the set/clear priority and the interrupt gating from the flag.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int ALM_W      = 8;
  localparam int NUM_FIELDS = 4;
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DATE = 3;

  typedef logic [ALM_W-1:0] alm_byte_t;

  // Wildcard code: both top bits set.
  function automatic logic is_wild(input alm_byte_t b);
    return &b[ALM_W-1:ALM_W-2];
  endfunction

  // Field hit: wildcard or full bitwise equality.
  function automatic logic field_hit(input alm_byte_t alm, input alm_byte_t cur);
    return is_wild(alm) || (alm == cur);
  endfunction
endpackage

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp
  import rtc_alarm_pkg::*;
(
  input  alm_byte_t alm_i,
  input  alm_byte_t cur_i,
  output logic      wild_o,
  output logic      hit_o
);
  assign wild_o = is_wild(alm_i);
  assign hit_o  = field_hit(alm_i, cur_i);

  // R2: a wildcard byte always hits; R3: a plain miss has differing bits
  always_comb begin
    if (wild_o) assert_wild_hits_R2: assert (hit_o);
    if (!wild_o && !hit_o) assert_miss_differs_R3: assert (alm_i != cur_i);
  end
endmodule

// File: rtl/alarm_flag_ctrl.sv
module alarm_flag_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);
  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> flag_o);
  assert_no_spurious_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_o && !set_i) |=> !flag_o);
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alarm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upd_tick,
  input  logic [7:0] now_sec,
  input  logic [7:0] now_min,
  input  logic [7:0] now_hour,
  input  logic [7:0] now_date,
  input  logic [7:0] alm_sec,
  input  logic [7:0] alm_min,
  input  logic [7:0] alm_hour,
  input  logic [7:0] alm_date,
  input  logic       alarm_en,
  input  logic       stat_rd,
  output logic       alarm_flag,
  output logic       alarm_irq
);
  alm_byte_t alm_vec [NUM_FIELDS];
  alm_byte_t cur_vec [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] hit_vec;
  logic [NUM_FIELDS-1:0] wild_vec;
  logic all_hit;
  logic match_evt;

  always_comb begin
    alm_vec[F_SEC]  = alm_sec;   cur_vec[F_SEC]  = now_sec;
    alm_vec[F_MIN]  = alm_min;   cur_vec[F_MIN]  = now_min;
    alm_vec[F_HOUR] = alm_hour;  cur_vec[F_HOUR] = now_hour;
    alm_vec[F_DATE] = alm_date;  cur_vec[F_DATE] = now_date;
  end

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    alarm_field_cmp u_cmp (
      .alm_i (alm_vec[g]),
      .cur_i (cur_vec[g]),
      .wild_o(wild_vec[g]),
      .hit_o (hit_vec[g])
    );
  end

  assign all_hit   = &hit_vec;
  assign match_evt = upd_tick && all_hit;

  alarm_flag_ctrl u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (match_evt),
    .clr_i (stat_rd),
    .flag_o(alarm_flag)
  );

  assign alarm_irq = alarm_flag && alarm_en;

  // R8: every field wildcarded means any strobe is an event
  assert_all_wild_fires_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_tick && (&wild_vec)) |=> alarm_flag);
  // R4: the flag only rises after a strobe
  assert_rise_needs_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_tick) |=> !$rose(alarm_flag));
  // R7: interrupt gated by enable
  assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq |-> (alarm_flag && alarm_en));
  assert_irq_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_flag && alarm_en) |-> alarm_irq);
endmodule

// File: tb/tb_rtc_alarm_match.sv
module tb_rtc_alarm_match;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upd_tick = 0, alarm_en = 0, stat_rd = 0;
  logic [7:0] now_sec = 0, now_min = 0, now_hour = 0, now_date = 0;
  logic [7:0] alm_sec = 0, alm_min = 0, alm_hour = 0, alm_date = 0;
  logic alarm_flag, alarm_irq;

  int n_tests = 0;
  int n_fail  = 0;
  logic exp_flag = 1'b0;
  int seed_dummy;

  always #2 clk = ~clk;

  rtc_alarm_match dut (
    .clk(clk), .rst_n(rst_n), .upd_tick(upd_tick),
    .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour), .now_date(now_date),
    .alm_sec(alm_sec), .alm_min(alm_min), .alm_hour(alm_hour), .alm_date(alm_date),
    .alarm_en(alarm_en), .stat_rd(stat_rd),
    .alarm_flag(alarm_flag), .alarm_irq(alarm_irq)
  );

  // Bench restatement: C0..FF is "any", otherwise exact byte.
  function automatic bit b_match(input logic [7:0] a, input logic [7:0] c);
    if (a >= 8'hC0) return 1'b1;
    return a == c;
  endfunction

  function automatic bit b_all(input logic [7:0] as, am, ah, ad, cs, cm, ch, cd);
    return b_match(as, cs) && b_match(am, cm) && b_match(ah, ch) && b_match(ad, cd);
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive at negedge, model, then sample just after the next posedge.
  task automatic step(input logic tick, input logic rd);
    @(negedge clk);
    upd_tick = tick;
    stat_rd  = rd;
    if (tick && b_all(alm_sec, alm_min, alm_hour, alm_date,
                      now_sec, now_min, now_hour, now_date))
      exp_flag = 1'b1;
    else if (rd)
      exp_flag = 1'b0;
    @(posedge clk);
    #1;
    upd_tick = 0;
    stat_rd  = 0;
  endtask

  task automatic set_alm(input logic [7:0] s, m, h, d);
    alm_sec = s; alm_min = m; alm_hour = h; alm_date = d;
  endtask

  task automatic set_now(input logic [7:0] s, m, h, d);
    now_sec = s; now_min = m; now_hour = h; now_date = d;
  endtask

  task automatic clear_flag();
    step(1'b0, 1'b1);
  endtask

  // Count alarms over a running BCD sequence of minutes and seconds.
  task automatic run_sweep(input string tag, input int expected);
    int fired = 0;
    for (int m = 0; m < 3; m++) begin
      for (int s = 0; s < 60; s++) begin
        now_min = 8'((m / 10) * 16 + (m % 10));
        now_sec = 8'((s / 10) * 16 + (s % 10));
        step(1'b1, 1'b0);
        if (alarm_flag) fired++;
        check(tag, alarm_flag, exp_flag);
        clear_flag();
      end
    end
    n_tests++;
    if (fired != expected) begin
      n_fail++;
      $display("FAIL %s: actual %0d alarms expected %0d", tag, fired, expected);
    end
  endtask

  function automatic logic [7:0] pick_alm(input logic [7:0] cur);
    int r = $urandom_range(0, 99);
    if (r < 25) return 8'hC0 | 8'($urandom_range(0, 63));
    if (r < 75) return cur;
    return 8'($urandom_range(0, 191));
  endfunction

  initial begin
    #(4 * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    seed_dummy = $urandom(32'h5EED_0042);
    repeat (3) @(posedge clk);
    #1;
    check("R1 flag after reset", alarm_flag, 1'b0);
    check("R1 irq after reset", alarm_irq, 1'b0);
    rst_n = 1'b1;

    // R4: exact daily match but no strobe
    set_now(8'h30, 8'h15, 8'h07, 8'h12);
    set_alm(8'h30, 8'h15, 8'h07, 8'h12);
    step(1'b0, 1'b0);
    check("R4 no strobe no flag", alarm_flag, 1'b0);
    step(1'b1, 1'b0);
    check("R4 daily exact match", alarm_flag, 1'b1);
    check("R7 irq off while disabled", alarm_irq, 1'b0);
    alarm_en = 1'b1;
    #1;
    check("R7 irq follows flag with enable", alarm_irq, 1'b1);

    // R5 sticky through mismatching strobes
    set_now(8'h31, 8'h15, 8'h07, 8'h12);
    step(1'b1, 1'b0);
    check("R5 flag sticky", alarm_flag, 1'b1);
    step(1'b0, 1'b1);
    check("R5 read clears", alarm_flag, 1'b0);
    check("R7 irq clears with flag", alarm_irq, 1'b0);

    // R6 set beats clear
    set_now(8'h30, 8'h15, 8'h07, 8'h12);
    step(1'b1, 1'b1);
    check("R6 set wins over read", alarm_flag, 1'b1);
    clear_flag();

    // R3 near-miss bytes
    set_alm(8'h30, 8'h15, 8'h81, 8'h12);
    set_now(8'h30, 8'h15, 8'h01, 8'h12);
    step(1'b1, 1'b0);
    check("R3 PM bit distinguishes 81h from 01h", alarm_flag, 1'b0);
    set_alm(8'h30, 8'hBF, 8'h07, 8'h12);
    set_now(8'h30, 8'h3F, 8'h07, 8'h12);
    step(1'b1, 1'b0);
    check("R3 BFh is not a wildcard", alarm_flag, 1'b0);

    // R2 lowest and highest wildcard codes
    set_alm(8'hC0, 8'hFF, 8'h07, 8'h12);
    set_now(8'h59, 8'h42, 8'h07, 8'h12);
    step(1'b1, 1'b0);
    check("R2 C0h and FFh match anything", alarm_flag, 1'b1);
    clear_flag();

    // R7 enable low still sets the flag
    alarm_en = 1'b0;
    step(1'b1, 1'b0);
    check("R7 flag set with enable low", alarm_flag, 1'b1);
    check("R7 irq low with enable low", alarm_irq, 1'b0);
    clear_flag();

    // R8 frequency patterns over 3 minutes of updates
    now_hour = 8'h09;
    now_date = 8'h05;
    set_alm(8'h20, 8'h01, 8'hC5, 8'hE0);
    run_sweep("R8 hourly pattern", 1);
    set_alm(8'h20, 8'hD3, 8'hC5, 8'hE0);
    run_sweep("R8 per-minute pattern", 3);
    set_alm(8'hF1, 8'hD3, 8'hC5, 8'hE0);
    run_sweep("R8 per-second pattern", 180);
    set_alm(8'h20, 8'h01, 8'h09, 8'h06);
    run_sweep("R8 daily pattern wrong date", 0);

    // Random mix (R2 R3 R4 R5 R6 R7)
    for (int i = 0; i < 3000; i++) begin
      set_now(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
      set_alm(pick_alm(now_sec), pick_alm(now_min), pick_alm(now_hour), pick_alm(now_date));
      alarm_en = 1'($urandom);
      step(($urandom_range(0, 9) < 7), ($urandom_range(0, 9) < 3));
      check("R4/R5/R6 random flag", alarm_flag, exp_flag);
      check("R7 random irq", alarm_irq, exp_flag & alarm_en);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule